// File: doc/BRIEF.md
# Age-Counter LRU Replacement Tracker

This block keeps an exact least-recently-used order for every set of a set-associative cache. Each way of each set carries a small age counter. The ages of one set always hold a permutation of 0 to WAYS-1. The way with the largest age is the most recent. The way with age zero is the next one to evict. Tags, data and hit/miss detection belong to the surrounding cache. This block only consumes events.

The cache reports a hit by raising `touch_vld` with the set index and the way that hit. It reports a refill by raising `fill_vld` with the set index. The refill always lands in that set's current victim way, so the way input is not used during a fill. Either event makes the touched way the youngest. Only the ways that were younger than it age by one step. A separate query port returns, combinationally, the victim way of any chosen set.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset, way w of every set holds age w. The victim of every set is therefore way 0.
- R2: `victim_way` is the way of set `query_set` whose age is 0. It follows `query_set` in the same cycle, with no clock edge in between.
- R3: When `fill_vld` is high, the victim way of set `acc_set` takes age WAYS-1, and every other way of that set drops its age by 1.
- R4: When `touch_vld` is high without `fill_vld`, and way `touch_way` holds age k, that way takes age WAYS-1. Ways of the set whose age is greater than k drop by 1. Ways whose age is below k keep their age.
- R5: A touch on the way that already holds age WAYS-1 leaves all ages of that set unchanged.
- R6: When `fill_vld` and `touch_vld` are high in the same cycle, the event is handled as a fill, and `touch_way` has no effect.
- R7: An event on one set leaves the ages of every other set unchanged.
- R8: Event inputs are sampled on the rising clock edge. A victim change appears only after that edge, never in the cycle in which the strobe is driven.
- R9: The ages of each set always form a permutation of 0 to WAYS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| touch_vld | input | 1 | A hit occurred on `touch_way` of set `acc_set` |
| fill_vld | input | 1 | A refill occurred into the victim way of set `acc_set` |
| acc_set | input | IDX_W (3) | Set index of the event |
| touch_way | input | WAY_W (2) | Way that hit; not used during a fill |
| query_set | input | IDX_W (3) | Set whose victim is requested |
| victim_way | output | WAY_W (2) | Way of `query_set` that currently holds age 0 |

## Verification
Ages update on the first rising edge that samples a strobe. The victim output needs no clock after the query changes. The bench drives each event on a falling edge. Before the next rising edge, it reads back the victim of the event's set and expects the old value (R8). It drops the strobe on the next falling edge. Only then does it sweep `query_set` over all sets, with a short settling delay per set. It compares each victim with an age model that the bench keeps itself. The sweep covers touches at every age, fills, touches on the youngest way, and fill-with-touch collisions across all eight sets.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

   // Width needed to number n items; at least one bit.
   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Event kind seen by one set.
   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_TOUCH = 2'd1,
      EV_FILL  = 2'd2
   } lru_event_e;

endpackage

// File: rtl/lru_age_victim_sel.sv
module lru_age_victim_sel #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned AGE_W = lru_age_pkg::bits_for(WAYS),
   parameter int unsigned WAY_W = lru_age_pkg::bits_for(WAYS)
) (
   input  logic [WAYS*AGE_W-1:0] ages_i,
   output logic [WAY_W-1:0]      victim_o
);

   logic [WAYS-1:0] is_zero;

   for (genvar w = 0; w < WAYS; w++) begin : g_zero
      assign is_zero[w] = (ages_i[w*AGE_W +: AGE_W] == '0);
   end

   // Lowest-numbered zero age wins; the ages form a permutation, so only one matches.
   always_comb begin
      victim_o = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (is_zero[w]) victim_o = WAY_W'(w);
      end
   end

endmodule

// File: rtl/lru_age_set.sv
module lru_age_set #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned AGE_W = lru_age_pkg::bits_for(WAYS),
   parameter int unsigned WAY_W = lru_age_pkg::bits_for(WAYS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd_en,
   input  logic [WAY_W-1:0]      upd_way,
   output logic [WAYS*AGE_W-1:0] ages_o
);

   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

   logic [AGE_W-1:0] age_q [WAYS];
   logic [AGE_W-1:0] ref_age;

   // Age of the way being promoted.
   always_comb begin
      ref_age = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (upd_way == WAY_W'(w)) ref_age = age_q[w];
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [AGE_W-1:0] age_d;

      always_comb begin
         age_d = age_q[w];
         if (upd_en) begin
            if (upd_way == WAY_W'(w))       age_d = AGE_MAX;
            else if (age_q[w] > ref_age)    age_d = age_q[w] - 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) age_q[w] <= AGE_W'(w);
         else        age_q[w] <= age_d;
      end

      assign ages_o[w*AGE_W +: AGE_W] = age_q[w];
   end

endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned SETS  = 8,
   localparam int unsigned AGE_W = lru_age_pkg::bits_for(WAYS),
   localparam int unsigned WAY_W = lru_age_pkg::bits_for(WAYS),
   localparam int unsigned IDX_W = lru_age_pkg::bits_for(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_vld,
   input  logic             fill_vld,
   input  logic [IDX_W-1:0] acc_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [IDX_W-1:0] query_set,
   output logic [WAY_W-1:0] victim_way
);

   import lru_age_pkg::*;

   localparam int unsigned SET_BITS = WAYS * AGE_W;

   if (WAYS < 2) begin : g_bad_ways
      $error("lru_age_tracker: WAYS must be at least 2");
   end
   if (SETS < 1) begin : g_bad_sets
      $error("lru_age_tracker: SETS must be at least 1");
   end

   logic [SETS-1:0][SET_BITS-1:0] set_ages;
   logic [SETS*SET_BITS-1:0]      ages_flat;
   logic [SET_BITS-1:0]           acc_ages;
   logic [SET_BITS-1:0]           qry_ages;
   logic [WAY_W-1:0]              acc_victim;
   logic [WAY_W-1:0]              tgt_way;
   lru_event_e                    ev;

   assign ages_flat = set_ages;

   always_comb begin
      if (fill_vld)       ev = EV_FILL;
      else if (touch_vld) ev = EV_TOUCH;
      else                ev = EV_NONE;
   end

   assign acc_ages = (int'(acc_set)   < SETS) ? set_ages[acc_set]   : '0;
   assign qry_ages = (int'(query_set) < SETS) ? set_ages[query_set] : '0;

   lru_age_victim_sel #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_acc_sel (
      .ages_i   (acc_ages),
      .victim_o (acc_victim)
   );

   lru_age_victim_sel #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_qry_sel (
      .ages_i   (qry_ages),
      .victim_o (victim_way)
   );

   // A fill lands in the current victim; a touch names its way.
   assign tgt_way = (ev == EV_FILL) ? acc_victim : touch_way;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic hit_here;
      assign hit_here = (ev != EV_NONE) && (acc_set == IDX_W'(s));

      lru_age_set #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_set (
         .clk     (clk),
         .rst_n   (rst_n),
         .upd_en  (hit_here),
         .upd_way (tgt_way),
         .ages_o  (set_ages[s])
      );
   end

endmodule

// File: rtl/lru_age_tracker_chk.sv
module lru_age_tracker_chk #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned SETS  = 8,
   localparam int unsigned AGE_W = lru_age_pkg::bits_for(WAYS),
   localparam int unsigned WAY_W = lru_age_pkg::bits_for(WAYS),
   localparam int unsigned IDX_W = lru_age_pkg::bits_for(SETS)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        touch_vld,
   input logic                        fill_vld,
   input logic [IDX_W-1:0]            acc_set,
   input logic [WAY_W-1:0]            touch_way,
   input logic [IDX_W-1:0]            query_set,
   input logic [WAY_W-1:0]            victim_way,
   input logic [SETS*WAYS*AGE_W-1:0]  ages_flat
);

   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

   function automatic logic [AGE_W-1:0] age_of(input logic [IDX_W-1:0] s,
                                               input logic [WAY_W-1:0] w);
      return ages_flat[(int'(s) * WAYS + int'(w)) * AGE_W +: AGE_W];
   endfunction

   function automatic logic [WAYS*AGE_W-1:0] set_of(input logic [IDX_W-1:0] s);
      return ages_flat[int'(s) * WAYS * AGE_W +: WAYS * AGE_W];
   endfunction

   logic set_ok, qry_ok, perm_ok;
   logic [WAY_W-1:0] chk_fill_way;

   assign set_ok = int'(acc_set)   < SETS;
   assign qry_ok = int'(query_set) < SETS;

   // Independent search for the zero-aged way of the access set.
   always_comb begin
      chk_fill_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (set_ok && age_of(acc_set, WAY_W'(w)) == '0) chk_fill_way = WAY_W'(w);
      end
   end

   // Every age value occurs exactly once in each set.
   always_comb begin
      perm_ok = 1'b1;
      for (int s = 0; s < SETS; s++) begin
         for (int v = 0; v < WAYS; v++) begin
            int hits;
            hits = 0;
            for (int w = 0; w < WAYS; w++) begin
               if (age_of(IDX_W'(s), WAY_W'(w)) == AGE_W'(v)) hits++;
            end
            if (hits != 1) perm_ok = 1'b0;
         end
      end
   end

   p_victim_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      qry_ok |-> age_of(query_set, victim_way) == '0);

   p_fill_youngest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_vld && set_ok) |=> age_of($past(acc_set), $past(chk_fill_way)) == AGE_MAX);

   p_touch_youngest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_vld && !fill_vld && set_ok) |=> age_of($past(acc_set), $past(touch_way)) == AGE_MAX);

   p_mru_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_vld && !fill_vld && set_ok && age_of(acc_set, touch_way) == AGE_MAX)
      |=> set_of($past(acc_set)) == $past(set_of(acc_set)));

   p_perm_r9: assert property (@(posedge clk) disable iff (!rst_n) perm_ok);

endmodule

bind lru_age_tracker lru_age_tracker_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .touch_vld  (touch_vld),
   .fill_vld   (fill_vld),
   .acc_set    (acc_set),
   .touch_way  (touch_way),
   .query_set  (query_set),
   .victim_way (victim_way),
   .ages_flat  (ages_flat)
);

// File: tb/lru_age_tracker_tb.sv
`timescale 1ns/1ps
module lru_age_tracker_tb;

   localparam int WAYS = 4;
   localparam int SETS = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       touch_vld = 1'b0;
   logic       fill_vld = 1'b0;
   logic [2:0] acc_set = '0;
   logic [1:0] touch_way = '0;
   logic [2:0] query_set = '0;
   logic [1:0] victim_way;

   int errors = 0;
   int checks = 0;
   int model [SETS][WAYS];

   always #2 clk = ~clk;

   lru_age_tracker #(.WAYS(WAYS), .SETS(SETS)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_vld  (touch_vld),
      .fill_vld   (fill_vld),
      .acc_set    (acc_set),
      .touch_way  (touch_way),
      .query_set  (query_set),
      .victim_way (victim_way)
   );

   function automatic int exp_victim(input int s);
      for (int w = 0; w < WAYS; w++) if (model[s][w] == 0) return w;
      return -1;
   endfunction

   function automatic int exp_mru(input int s);
      for (int w = 0; w < WAYS; w++) if (model[s][w] == WAYS - 1) return w;
      return -1;
   endfunction

   function automatic void model_promote(input int s, input int t);
      int k;
      k = model[s][t];
      for (int w = 0; w < WAYS; w++) begin
         if (w == t)             model[s][w] = WAYS - 1;
         else if (model[s][w] > k) model[s][w] = model[s][w] - 1;
      end
   endfunction

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: victim got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic sweep(input string req);
      for (int s = 0; s < SETS; s++) begin
         query_set = 3'(s);
         #0.1;
         check(req, int'(victim_way), exp_victim(s));
      end
   endtask

   // One event: drive on a falling edge, confirm no early change (R8), settle, sweep.
   task automatic do_event(input bit is_touch, input bit is_fill, input int s,
                           input int w, input string req);
      @(negedge clk);
      touch_vld = is_touch;
      fill_vld  = is_fill;
      acc_set   = 3'(s);
      touch_way = 2'(w);
      query_set = 3'(s);
      #0.5;
      check("R8", int'(victim_way), exp_victim(s));
      if (is_fill)       model_promote(s, exp_victim(s));
      else if (is_touch) model_promote(s, w);
      @(negedge clk);
      touch_vld = 1'b0;
      fill_vld  = 1'b0;
      sweep(req);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) model[s][w] = w;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R1");                                   // victim is way 0 everywhere
      for (int s = 0; s < SETS; s++) begin
         query_set = 3'(s);
         #0.1;
         check("R2", int'(victim_way), 0);           // combinational follow of query
      end

      // R4: touch each way of every set in a set-dependent order; R7 by full sweeps.
      for (int s = 0; s < SETS; s++) begin
         for (int k = 0; k < WAYS; k++) begin
            do_event(1'b1, 1'b0, s, (s * 3 + k * 5 + 1) % WAYS, "R4");
         end
      end

      // R3: repeated fills rotate through the LRU way of each set.
      for (int s = 0; s < SETS; s++) begin
         for (int k = 0; k < 3; k++) do_event(1'b0, 1'b1, s, 0, "R3");
      end

      // R5: touch the youngest way; victim of every set is unchanged.
      for (int s = 0; s < SETS; s++) do_event(1'b1, 1'b0, s, exp_mru(s), "R5");

      // R6: fill and touch together; touch_way names a non-victim way and must be ignored.
      for (int s = 0; s < SETS; s++) begin
         do_event(1'b1, 1'b1, s, (exp_victim(s) + 1) % WAYS, "R6");
      end

      // R4/R9: mixed stream of touches at middle ages and fills on two sets.
      for (int k = 0; k < 24; k++) begin
         int s;
         s = (k % 2 == 0) ? 2 : 5;
         if (k % 3 == 0) do_event(1'b0, 1'b1, s, 0, "R9");
         else            do_event(1'b1, 1'b0, s, (k * 7) % WAYS, "R9");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule